// File: doc/BRIEF.md
# Mains-Locked Stepping Clock Coil Driver

This block turns the 100 Hz pulse train taken from full-wave rectified 50 Hz mains into drive for a bipolar stepping clock movement. The raw pulse is first brought into the system clock domain. It is then filtered so that a level only counts once it has held for a set number of system clocks. The block counts rising edges of the filtered signal with a units decade and a tens decade. The tens decade advances only when the units decade rolls over, so one full second passes every hundred edges.

At each one-second rollover the block flips a polarity bit and raises a one-cycle tick strobe. It also starts a short coil pulse on the line that belongs to the new polarity. The pulse lasts a set number of system clocks. It is further gated by the first half of the second, meaning the tens decade is below its midpoint. Consecutive seconds therefore step the movement with opposite current, and only one line is active at a time.

Top module: `mains_step_driver`

## Requirements
- R1: While the synchronous reset `rst` is high, `coil_a`, `coil_b` and `tick` are 0. Reset clears both decades and the polarity bit, so the first `tick` after reset follows exactly 100 valid input pulses, and the first coil pulse appears on `coil_a`.
- R2: A level on `mains_pulse` that lasts fewer than `DEB_CYCLES` system clocks, after the two-flop synchroniser, is ignored and does not advance the count.
- R3: Each rising edge of the filtered input advances the units decade (values 0 to `LO_MOD-1`) exactly once. The tens decade advances only on a units rollover. `tick` therefore fires once per `LO_MOD*HI_MOD` (default 100) valid input pulses.
- R4: `tick` is high for exactly one system clock cycle per rollover.
- R5: Coil pulses alternate between `coil_a` and `coil_b` on consecutive ticks.
- R6: `coil_a` and `coil_b` are never high in the same cycle.
- R7: A coil pulse rises in the same cycle that `tick` is high. It lasts `PULSE_CYCLES` system clocks if that ends before the tens decade reaches `HI_MOD/2`.
- R8: If the tens decade reaches `HI_MOD/2` first (half a second of input edges after the tick), the coil pulse ends in the cycle after that count is reached.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| mains_pulse | input | 1 | Raw 100 Hz pulse from the rectified mains, asynchronous |
| coil_a | output | 1 | Coil drive, first polarity |
| coil_b | output | 1 | Coil drive, opposite polarity |
| tick | output | 1 | One-cycle strobe at each one-second rollover |

## Verification
The bench builds the block with `DEB_CYCLES=3` and `PULSE_CYCLES=600`, and keeps the default decade moduli of 10. Under these values a simulated second is only 800 to 1600 system clocks long, so six full seconds fit easily in one run. With input pulse half-periods of 8 and 4 cycles, half a second lasts either longer or shorter than 600 cycles. The same build therefore shows both full-width coil pulses and pulses cut short by the half-second gate. Two-cycle glitches in the low phase stay below the three-cycle filter and must not change the count of 100 pulses per tick.

// File: rtl/mains_step_driver.sv
module mains_step_driver #(
  parameter int unsigned DEB_CYCLES   = 50000,
  parameter int unsigned PULSE_CYCLES = 1500000,
  parameter int unsigned LO_MOD       = 10,
  parameter int unsigned HI_MOD       = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic mains_pulse,
  output logic coil_a,
  output logic coil_b,
  output logic tick
);
  localparam int DW = (DEB_CYCLES > 1) ? $clog2(DEB_CYCLES) : 1;
  localparam int PW = $clog2(PULSE_CYCLES + 1);
  localparam int LW = $clog2(LO_MOD);
  localparam int HW = $clog2(HI_MOD);
  localparam logic [DW-1:0] DEB_LAST = DW'(DEB_CYCLES - 1);
  localparam logic [PW-1:0] PW_LOAD  = PW'(PULSE_CYCLES);
  localparam logic [LW-1:0] LO_LAST  = LW'(LO_MOD - 1);
  localparam logic [HW-1:0] HI_LAST  = HW'(HI_MOD - 1);
  localparam logic [HW-1:0] HI_HALF  = HW'(HI_MOD / 2);

  logic          sync1, sync2, filt, filt_d, phase;
  logic [DW-1:0] deb_cnt;
  logic [LW-1:0] lo_cnt;
  logic [HW-1:0] hi_cnt;
  logic [PW-1:0] pw_cnt;
  logic          rise, lo_wrap, wrap, drive;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync1   <= 1'b0;
      sync2   <= 1'b0;
      filt    <= 1'b0;
      filt_d  <= 1'b0;
      deb_cnt <= '0;
    end else begin
      sync1  <= mains_pulse;
      sync2  <= sync1;
      filt_d <= filt;
      if (sync2 == filt) begin
        deb_cnt <= '0;
      end else if (deb_cnt == DEB_LAST) begin
        filt    <= sync2;
        deb_cnt <= '0;
      end else begin
        deb_cnt <= deb_cnt + 1'b1;
      end
    end
  end

  assign rise    = filt & ~filt_d;
  assign lo_wrap = rise && (lo_cnt == LO_LAST);
  assign wrap    = lo_wrap && (hi_cnt == HI_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_cnt <= '0;
      hi_cnt <= '0;
      phase  <= 1'b0;
      tick   <= 1'b0;
      pw_cnt <= '0;
    end else begin
      tick <= wrap;
      if (rise) lo_cnt <= lo_wrap ? '0 : lo_cnt + 1'b1;
      if (lo_wrap) hi_cnt <= wrap ? '0 : hi_cnt + 1'b1;
      if (wrap) begin
        phase  <= ~phase;
        pw_cnt <= PW_LOAD;
      end else if (pw_cnt != '0) begin
        pw_cnt <= pw_cnt - 1'b1;
      end
    end
  end

  assign drive  = (pw_cnt != '0) && (hi_cnt < HI_HALF);
  assign coil_a = drive & phase;
  assign coil_b = drive & ~phase;

  AST_FILT_HELD: assert property (@(posedge clk) disable iff (rst)
    (filt != $past(filt)) |-> ($past(sync2) == filt)); // R2
  AST_LO_RANGE: assert property (@(posedge clk) disable iff (rst)
    lo_cnt <= LO_LAST); // R3
  AST_HI_ON_CARRY: assert property (@(posedge clk) disable iff (rst)
    (hi_cnt != $past(hi_cnt)) |-> ($past(rise) && $past(lo_cnt) == LO_LAST)); // R3
  AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick); // R4
  AST_COIL_START: assert property (@(posedge clk) disable iff (rst)
    ($rose(coil_a) || $rose(coil_b)) |-> tick); // R7
endmodule

// File: tb/mains_step_driver_tb_top.sv
module mains_step_driver_tb_top;
  localparam int DEB   = 3;
  localparam int PULSE = 600;
  localparam int NSEC  = 6;

  logic clk = 1'b0, rst = 1'b1, raw = 1'b0;
  logic coil_a, coil_b, tick;
  always #2 clk = ~clk;

  mains_step_driver #(.DEB_CYCLES(DEB), .PULSE_CYCLES(PULSE)) dut_i (
    .clk(clk), .rst(rst), .mains_pulse(raw),
    .coil_a(coil_a), .coil_b(coil_b), .tick(tick));

  int checks = 0, failures = 0;
  int raw_cnt = 0, tick_total = 0;
  bit exp_pol[$];
  int exp_w[$];
  bit done = 0, ended = 0;
  int half_tab[NSEC+1] = '{8, 8, 8, 4, 4, 4, 4};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  task automatic drive_pulses(input int n, input int h, input bit glitch, input bit count);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      raw = 1'b1;
      if (count) raw_cnt++;
      repeat (h - 1) @(negedge clk);
      @(negedge clk);
      raw = 1'b0;
      if (glitch && h >= 8) begin
        repeat (2) @(negedge clk);
        raw = 1'b1;
        repeat (2) @(negedge clk);
        raw = 1'b0;
        repeat (h - 5) @(negedge clk);
      end else begin
        repeat (h - 1) @(negedge clk);
      end
    end
  endtask

  task automatic drive_second(input int s);
    int w;
    w = 2 * half_tab[s] + 98 * half_tab[s+1];
    if (w > PULSE) w = PULSE;
    exp_pol.push_back((s % 2) == 0);
    exp_w.push_back(w);
    drive_pulses(100, half_tab[s], s == 1, 1'b1);
  endtask

  int run_len = 0;
  bit run_pol = 0, overlap = 0, tick_prev = 0;

  always @(negedge clk) begin
    if (!rst && !ended) begin
      if (coil_a && coil_b) overlap = 1;
      if (coil_a || coil_b) begin
        if (run_len == 0) run_pol = coil_a;
        run_len++;
      end else if (run_len > 0) begin
        chk(!overlap, "R6 coil lines overlapped", overlap, 0);
        if (exp_w.size() == 0) begin
          chk(0, "R5 unexpected coil pulse", run_len, 0);
        end else begin
          automatic bit p = exp_pol.pop_front();
          automatic int w = exp_w.pop_front();
          chk(run_pol == p, "R5 polarity (1=coil_a)", run_pol, p);
          if (w == PULSE) chk(run_len == w, "R7 pulse width", run_len, w);
          else chk(run_len == w, "R8 truncated pulse width", run_len, w);
        end
        run_len = 0;
        overlap = 0;
      end
      if (tick_prev) chk(!tick, "R4 tick longer than one cycle", tick, 0);
      if (tick) begin
        tick_total++;
        chk(raw_cnt == 100, "R3 input pulses per tick", raw_cnt, 100);
        chk(coil_a || coil_b, "R7 coil starts with tick", coil_a | coil_b, 1);
        raw_cnt = 0;
      end
      tick_prev = tick;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    chk(0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    raw = 1'b1;
    repeat (5) @(negedge clk);
    chk(!coil_a && !coil_b && !tick, "R1 outputs in reset", {coil_a, coil_b, tick}, 0);
    raw = 1'b0;
    repeat (5) @(negedge clk);
    chk(!coil_a && !coil_b && !tick, "R1 outputs in reset, input low", {coil_a, coil_b, tick}, 0);
    rst = 1'b0;
    repeat (20) @(negedge clk);
    chk(!coil_a && !coil_b && !tick, "R1 outputs idle after reset", {coil_a, coil_b, tick}, 0);
    for (int s = 0; s < NSEC; s++) drive_second(s);
    drive_pulses(60, half_tab[NSEC], 1'b0, 1'b0);
    repeat (700) @(negedge clk);
    chk(tick_total == NSEC, "R3 total ticks", tick_total, NSEC);
    chk(exp_w.size() == 0, "R5 pulses outstanding", exp_w.size(), 0);
    done = 1;
    finish_run();
  end
endmodule